// File: doc/BRIEF.md
# Interleaved Write Data Demultiplexer

This block is the write side of a slave on an AXI3-style bus. Write addresses are stored in a small table of open transactions, one slot per transaction. Write data beats can arrive mixed across several open transactions. Each beat carries its own ID, and that ID, not the order of arrival, decides which transaction the beat belongs to. The block counts beats per transaction. It presents each accepted beat on a simple output with the beat's address, index, data and strobe. When a transaction has received all of its beats, the block returns a write response whose ID equals that transaction's ID.

Two parameters shape the block. `SLOTS` is the number of table entries, so it bounds how many addresses may be outstanding. `DEPTH` is the interleaving depth: the number of transactions whose data may be partly received at the same time. A new transaction's data is refused while `DEPTH` others are in progress. With `DEPTH` set to 1, data must arrive one transaction after another. Responses go out in slot order rather than address order, so different IDs may complete out of order. The read channels are separate and are not part of this block.

Top module: `wr_interleave_demux`

## Requirements
- R1: While reset is applied and on the first cycle after it, `aw_ready` is 1, `w_ready` is 0, `b_valid` is 0 and `beat_valid` is 0.
- R2: `aw_ready` is 1 exactly when some slot is free and no occupied slot (waiting for data, receiving data or waiting to respond) holds an ID equal to `aw_id`. An accepted address is stored in the free slot with the lowest index.
- R3: A data beat is accepted only if `w_id` equals the ID of a slot that is waiting for data or receiving data. A beat whose ID matches no such slot sees `w_ready` = 0 and has no effect.
- R4: A beat that would start the data of a transaction is refused (`w_ready` = 0) while `DEPTH` transactions already have some but not all of their beats. Beats of those transactions are still accepted.
- R5: One cycle after a beat is accepted, `beat_valid` is 1 for one cycle. In that cycle `beat_id` equals the beat's `w_id` and `beat_idx` is the 0-based position of the beat in its transaction. `beat_addr` equals the start address plus `beat_idx` times `DATA_W/8`. `beat_data` and `beat_strb` equal the beat's data and strobe.
- R6: A transaction with length field L (the field `aw_len`) completes on its L+1-th beat. `w_last` is 1 on that beat and on no earlier beat.
- R7: If the response output is idle, `b_valid` rises two clock edges after the final beat of a transaction is accepted. `b_id` equals that transaction's ID and `b_resp` is 2'b00 (OKAY).
- R8: While `b_valid` is 1 and `b_ready` is 0, `b_valid` and `b_id` hold their values. The slot becomes free at the edge where `b_valid` and `b_ready` are both 1.
- R9: If several transactions are waiting to respond, the one in the lowest-index slot is presented first, whatever order its address came in. After each response handshake, `b_valid` is 0 for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| aw_valid | input | 1 | Write address valid |
| aw_ready | output | 1 | Write address ready |
| aw_id | input | ID_W | Write address ID |
| aw_addr | input | ADDR_W | Start byte address of the burst |
| aw_len | input | LEN_W | Burst length field (beats minus one) |
| w_valid | input | 1 | Write data valid |
| w_ready | output | 1 | Write data ready |
| w_id | input | ID_W | ID carried by this data beat |
| w_data | input | DATA_W | Write data |
| w_strb | input | DATA_W/8 | Byte strobes |
| w_last | input | 1 | Final beat of the burst |
| b_valid | output | 1 | Write response valid |
| b_ready | input | 1 | Write response ready |
| b_id | output | ID_W | Response ID, equal to the transaction's ID |
| b_resp | output | 2 | Response code, always OKAY |
| beat_valid | output | 1 | An accepted beat is presented |
| beat_id | output | ID_W | ID of the presented beat |
| beat_addr | output | ADDR_W | Byte address of the presented beat |
| beat_idx | output | LEN_W | Beat position inside its burst |
| beat_data | output | DATA_W | Data of the presented beat |
| beat_strb | output | DATA_W/8 | Strobe of the presented beat |

## Verification
`aw_ready`, `w_ready` and `b_id` depend only on the current slot table and on the IDs being offered, so they are due in the same cycle as the stimulus. The beat outputs are due one edge after acceptance, and `b_valid` is due two edges after the final beat. The bench drives inputs on the falling edge and compares every output 1 ns before the next rising edge. Its reference model advances once per edge, so a value due after one register is compared one cycle later and a value due after two registers is compared two cycles later. The stimulus includes ID clashes on the address channel, beats with unknown IDs, beats refused at the depth limit and long stalls on `b_ready`. It also includes responses that finish out of address order.

// File: rtl/wid_pkg.sv
package wid_pkg;

  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_ADDR = 2'd1,
    SLOT_DATA = 2'd2,
    SLOT_RESP = 2'd3
  } slot_state_e;

  localparam logic [1:0] RESP_OKAY = 2'b00;

endpackage

// File: rtl/wid_pick.sv
module wid_pick #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);

  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end

endmodule

// File: rtl/wid_slot.sv
module wid_slot
  import wid_pkg::*;
#(
  parameter int ID_W       = 4,
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 4,
  parameter int BYTE_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              take_i,
  input  logic              release_i,
  output slot_state_e       state_o,
  output logic [ID_W-1:0]   id_o,
  output logic [ADDR_W-1:0] beat_addr_o,
  output logic [LEN_W-1:0]  count_o,
  output logic              final_o
);

  slot_state_e       state_q, state_d;
  logic [ID_W-1:0]   id_q;
  logic [ADDR_W-1:0] base_q;
  logic [LEN_W-1:0]  len_q, count_q;
  logic              load_en, count_en;

  assign final_o     = (count_q == len_q);
  assign state_o     = state_q;
  assign id_o        = id_q;
  assign count_o     = count_q;
  assign beat_addr_o = base_q + (ADDR_W'(count_q) << BYTE_SHIFT);

  always_comb begin
    state_d  = state_q;
    load_en  = 1'b0;
    count_en = 1'b0;
    unique case (state_q)
      SLOT_FREE: if (alloc_i) begin
        state_d = SLOT_ADDR;
        load_en = 1'b1;
      end
      SLOT_ADDR, SLOT_DATA: if (take_i) begin
        count_en = 1'b1;
        state_d  = final_o ? SLOT_RESP : SLOT_DATA;
      end
      SLOT_RESP: if (release_i) state_d = SLOT_FREE;
      default: state_d = SLOT_FREE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SLOT_FREE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q    <= '0;
      base_q  <= '0;
      len_q   <= '0;
      count_q <= '0;
    end else if (load_en) begin
      id_q    <= id_i;
      base_q  <= addr_i;
      len_q   <= len_i;
      count_q <= '0;
    end else if (count_en) begin
      count_q <= count_q + 1'b1;
    end
  end

  // R3: a beat is steered only into a slot that expects data
  assert_take_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |-> (state_q == SLOT_ADDR || state_q == SLOT_DATA))
    else $error("beat steered into a slot not expecting data");

  // R2: an address is only stored into a free slot
  assert_alloc_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_i |-> (state_q == SLOT_FREE))
    else $error("address stored into an occupied slot");

endmodule

// File: rtl/wr_interleave_demux.sv
module wr_interleave_demux
  import wid_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 4,
  parameter int SLOTS  = 4,
  parameter int DEPTH  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                aw_valid,
  output logic                aw_ready,
  input  logic [ID_W-1:0]     aw_id,
  input  logic [ADDR_W-1:0]   aw_addr,
  input  logic [LEN_W-1:0]    aw_len,
  input  logic                w_valid,
  output logic                w_ready,
  input  logic [ID_W-1:0]     w_id,
  input  logic [DATA_W-1:0]   w_data,
  input  logic [DATA_W/8-1:0] w_strb,
  input  logic                w_last,
  output logic                b_valid,
  input  logic                b_ready,
  output logic [ID_W-1:0]     b_id,
  output logic [1:0]          b_resp,
  output logic                beat_valid,
  output logic [ID_W-1:0]     beat_id,
  output logic [ADDR_W-1:0]   beat_addr,
  output logic [LEN_W-1:0]    beat_idx,
  output logic [DATA_W-1:0]   beat_data,
  output logic [DATA_W/8-1:0] beat_strb
);

  localparam int STRB_W     = DATA_W / 8;
  localparam int BYTE_SHIFT = $clog2(STRB_W);
  localparam int IDX_W      = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int CNT_W      = $clog2(SLOTS + 1);

  slot_state_e       slot_st    [SLOTS];
  logic [ID_W-1:0]   slot_id    [SLOTS];
  logic [ADDR_W-1:0] slot_addr  [SLOTS];
  logic [LEN_W-1:0]  slot_cnt   [SLOTS];
  logic [SLOTS-1:0]  slot_final;

  logic [SLOTS-1:0] free_vec, data_vec, resp_vec, match_vec, clash_vec;
  logic [SLOTS-1:0] alloc_vec, take_vec, release_vec;
  logic             free_any, match_any, resp_any;
  logic [IDX_W-1:0] free_idx, match_idx, resp_idx;
  logic [CNT_W-1:0] active_cnt;
  logic             aw_take, w_take, b_take, depth_ok;

  logic             b_vld_q, b_vld_d;
  logic [IDX_W-1:0] b_idx_q, b_idx_d;

  // slot table
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    wid_slot #(
      .ID_W(ID_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BYTE_SHIFT(BYTE_SHIFT)
    ) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_i    (alloc_vec[g]),
      .id_i       (aw_id),
      .addr_i     (aw_addr),
      .len_i      (aw_len),
      .take_i     (take_vec[g]),
      .release_i  (release_vec[g]),
      .state_o    (slot_st[g]),
      .id_o       (slot_id[g]),
      .beat_addr_o(slot_addr[g]),
      .count_o    (slot_cnt[g]),
      .final_o    (slot_final[g])
    );

    assign free_vec[g]    = (slot_st[g] == SLOT_FREE);
    assign data_vec[g]    = (slot_st[g] == SLOT_DATA);
    assign resp_vec[g]    = (slot_st[g] == SLOT_RESP);
    assign clash_vec[g]   = !free_vec[g] && (slot_id[g] == aw_id);
    assign match_vec[g]   = (slot_st[g] == SLOT_ADDR || data_vec[g]) && (slot_id[g] == w_id);
    assign alloc_vec[g]   = aw_take && (free_idx == IDX_W'(g));
    assign take_vec[g]    = w_take && (match_idx == IDX_W'(g));
    assign release_vec[g] = b_take && (b_idx_q == IDX_W'(g));
  end

  wid_pick #(.N(SLOTS)) u_pick_free  (.req_i(free_vec),  .any_o(free_any),  .idx_o(free_idx));
  wid_pick #(.N(SLOTS)) u_pick_match (.req_i(match_vec), .any_o(match_any), .idx_o(match_idx));
  wid_pick #(.N(SLOTS)) u_pick_resp  (.req_i(resp_vec),  .any_o(resp_any),  .idx_o(resp_idx));

  // acceptance
  assign active_cnt = CNT_W'($countones(data_vec));
  assign depth_ok   = |(match_vec & data_vec) || (active_cnt < CNT_W'(DEPTH));
  assign aw_ready   = free_any && !(|clash_vec);
  assign w_ready    = match_any && depth_ok;
  assign aw_take    = aw_valid && aw_ready;
  assign w_take     = w_valid && w_ready;
  assign b_take     = b_vld_q && b_ready;

  // response stage
  always_comb begin
    b_vld_d = b_vld_q;
    b_idx_d = b_idx_q;
    if (b_vld_q) begin
      if (b_ready) b_vld_d = 1'b0;
    end else if (resp_any) begin
      b_vld_d = 1'b1;
      b_idx_d = resp_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_vld_q <= 1'b0;
      b_idx_q <= '0;
    end else begin
      b_vld_q <= b_vld_d;
      b_idx_q <= b_idx_d;
    end
  end

  assign b_valid = b_vld_q;
  assign b_id    = slot_id[b_idx_q];
  assign b_resp  = RESP_OKAY;

  // beat output stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beat_valid <= 1'b0;
    else        beat_valid <= w_take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_id   <= '0;
      beat_addr <= '0;
      beat_idx  <= '0;
      beat_data <= '0;
      beat_strb <= '0;
    end else if (w_take) begin
      beat_id   <= w_id;
      beat_addr <= slot_addr[match_idx];
      beat_idx  <= slot_cnt[match_idx];
      beat_data <= w_data;
      beat_strb <= w_strb;
    end
  end

  // checks
  logic id_dup;
  always_comb begin
    id_dup = 1'b0;
    for (int i = 0; i < SLOTS; i++)
      for (int j = i + 1; j < SLOTS; j++)
        if (!free_vec[i] && !free_vec[j] && slot_id[i] == slot_id[j]) id_dup = 1'b1;
  end

  assert_unique_id_R2: assert property (@(posedge clk) disable iff (!rst_n) !id_dup)
    else $error("two occupied slots share an ID");

  assert_interleave_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(data_vec) <= DEPTH)
    else $error("more partly received transactions than the depth");

  assert_beat_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    w_take |=> beat_valid && beat_id == $past(w_id))
    else $error("accepted beat not presented on the next cycle");

  assert_last_on_final_R6: assert property (@(posedge clk) disable iff (!rst_n)
    w_take |-> (w_last == slot_final[match_idx]))
    else $error("w_last does not mark the final counted beat");

  assert_bid_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    b_valid && !b_ready |=> b_valid && $stable(b_id))
    else $error("response changed while stalled");

endmodule

// File: tb/wr_interleave_demux_test.sv
`timescale 1ns/1ps
module wr_interleave_demux_test;

  localparam int ID_W = 4, ADDR_W = 32, DATA_W = 32, LEN_W = 4, SLOTS = 4, DEPTH = 2;
  localparam int STRB_W = DATA_W / 8;

  logic clk = 1'b0;
  logic rst_n;
  logic aw_valid, aw_ready, w_valid, w_ready, w_last, b_valid, b_ready, beat_valid;
  logic [ID_W-1:0] aw_id, w_id, b_id, beat_id;
  logic [ADDR_W-1:0] aw_addr, beat_addr;
  logic [LEN_W-1:0] aw_len, beat_idx;
  logic [DATA_W-1:0] w_data, beat_data;
  logic [STRB_W-1:0] w_strb, beat_strb;
  logic [1:0] b_resp;

  always #2 clk = ~clk;

  wr_interleave_demux #(.ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W),
                        .SLOTS(SLOTS), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id), .aw_addr(aw_addr), .aw_len(aw_len),
    .w_valid(w_valid), .w_ready(w_ready), .w_id(w_id), .w_data(w_data), .w_strb(w_strb),
    .w_last(w_last), .b_valid(b_valid), .b_ready(b_ready), .b_id(b_id), .b_resp(b_resp),
    .beat_valid(beat_valid), .beat_id(beat_id), .beat_addr(beat_addr), .beat_idx(beat_idx),
    .beat_data(beat_data), .beat_strb(beat_strb));

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // reference model: 0 free, 1 waiting data, 2 receiving, 3 awaiting response
  int m_st [SLOTS];
  int m_id [SLOTS];
  int m_len[SLOTS];
  int m_cnt[SLOTS];
  logic [ADDR_W-1:0] m_addr[SLOTS];
  bit m_bv; int m_bidx;
  bit m_ov; int m_oid, m_oidx; logic [ADDR_W-1:0] m_oaddr;
  logic [DATA_W-1:0] m_odata; logic [STRB_W-1:0] m_ostrb;

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    bit exp_awr, exp_wr, any_clash;
    int fi, mi, ri, active;
    #1;
    fi = -1; mi = -1; ri = -1; active = 0; any_clash = 0;
    for (int k = SLOTS - 1; k >= 0; k--) begin
      if (m_st[k] == 0) fi = k;
      if (m_st[k] == 3) ri = k;
      if (m_st[k] != 0 && m_id[k] == int'(aw_id)) any_clash = 1;
      if ((m_st[k] == 1 || m_st[k] == 2) && m_id[k] == int'(w_id)) mi = k;
      if (m_st[k] == 2) active++;
    end
    exp_awr = (fi >= 0) && !any_clash;
    exp_wr  = (mi >= 0) && (m_st[mi] == 2 || active < DEPTH);
    chk("R2 aw_ready", aw_ready, exp_awr);
    chk("R3 R4 w_ready", w_ready, exp_wr);
    chk("R7 b_valid", b_valid, m_bv);
    if (m_bv) begin
      chk("R8 R9 b_id", b_id, m_id[m_bidx]);
      chk("R7 b_resp", b_resp, 0);
    end
    chk("R5 beat_valid", beat_valid, m_ov);
    if (m_ov) begin
      chk("R5 beat_id", beat_id, m_oid);
      chk("R5 beat_idx", beat_idx, m_oidx);
      chk("R5 beat_addr", beat_addr, m_oaddr);
      chk("R5 beat_data", beat_data, m_odata);
      chk("R5 beat_strb", beat_strb, m_ostrb);
    end
    // advance model by one edge (R6: final beat is count == len)
    if (m_bv) begin
      if (b_ready) begin m_st[m_bidx] = 0; m_bv = 0; end
    end else if (ri >= 0) begin
      m_bv = 1; m_bidx = ri;
    end
    m_ov = w_valid && exp_wr;
    if (m_ov) begin
      m_oid = mi == -1 ? 0 : m_id[mi];
      m_oidx = m_cnt[mi];
      m_oaddr = m_addr[mi] + ADDR_W'(m_cnt[mi] * STRB_W);
      m_odata = w_data; m_ostrb = w_strb;
      if (m_cnt[mi] == m_len[mi]) m_st[mi] = 3;
      else begin m_st[mi] = 2; m_cnt[mi]++; end
    end
    if (aw_valid && exp_awr) begin
      m_st[fi] = 1; m_id[fi] = int'(aw_id); m_len[fi] = int'(aw_len);
      m_addr[fi] = aw_addr; m_cnt[fi] = 0;
    end
    @(negedge clk);
  endtask

  task automatic drive_aw(bit v, int id, int len, logic [ADDR_W-1:0] a);
    aw_valid = v; aw_id = ID_W'(id); aw_len = LEN_W'(len); aw_addr = a;
  endtask

  task automatic drive_w(bit v, int id, bit last);
    w_valid = v; w_id = ID_W'(id); w_last = last;
    w_data = $urandom; w_strb = STRB_W'($urandom);
  endtask

  // random master: W beats drawn from open transactions, sometimes unknown IDs
  task automatic rand_inputs();
    int open_list[$];
    int s, bogus;
    bit hit;
    drive_aw(($urandom % 3) != 0, $urandom % 6, $urandom % 4, $urandom & 32'hFFFF_FFFC);
    for (int k = 0; k < SLOTS; k++) if (m_st[k] == 1 || m_st[k] == 2) open_list.push_back(k);
    if (open_list.size() == 0 || ($urandom % 5) == 0) begin
      bogus = $urandom % 16; hit = 0;
      for (int k = 0; k < SLOTS; k++) if ((m_st[k] == 1 || m_st[k] == 2) && m_id[k] == bogus) hit = 1;
      if (!hit) drive_w(($urandom % 2) == 0, bogus, $urandom % 2);
      else drive_w(0, 0, 0);
    end else begin
      s = open_list[$urandom % open_list.size()];
      drive_w(($urandom % 4) != 0, m_id[s], m_cnt[s] == m_len[s]);
    end
    b_ready = ($urandom % 10) < 6;
  endtask

  initial begin
    for (int k = 0; k < SLOTS; k++) begin m_st[k] = 0; m_id[k] = 0; m_len[k] = 0; m_cnt[k] = 0; m_addr[k] = 0; end
    m_bv = 0; m_bidx = 0; m_ov = 0; m_oid = 0; m_oidx = 0; m_oaddr = 0; m_odata = 0; m_ostrb = 0;
    rst_n = 1'b0;
    drive_aw(0, 0, 0, 0); drive_w(0, 0, 0); b_ready = 0;
    repeat (3) @(negedge clk);
    // R1: values during reset
    chk("R1 aw_ready in reset", aw_ready, 1);
    chk("R1 w_ready in reset", w_ready, 0);
    chk("R1 b_valid in reset", b_valid, 0);
    chk("R1 beat_valid in reset", beat_valid, 0);
    rst_n = 1'b1;
    tick();
    // directed: depth limit, unknown ID, ID clash, out-of-order responses
    drive_aw(1, 5, 1, 32'h100); tick();           // slot0
    drive_aw(1, 6, 1, 32'h200); tick();           // slot1
    drive_aw(1, 7, 0, 32'h300); tick();           // slot2
    drive_aw(1, 5, 0, 32'h400); tick();           // R2: clash with open ID 5
    drive_aw(0, 0, 0, 0);
    drive_w(1, 5, 0); tick();                     // starts ID 5
    drive_w(1, 6, 0); tick();                     // starts ID 6, depth now full
    drive_w(1, 7, 1); tick();                     // R4: held
    drive_w(1, 9, 1); tick();                     // R3: unknown ID held
    drive_w(1, 6, 1); tick();                     // completes ID 6 (slot1)
    drive_w(1, 7, 1); tick();                     // now allowed
    drive_w(1, 5, 1); tick();                     // completes ID 5 (slot0)
    drive_w(0, 0, 0);
    repeat (4) tick();                            // R8: stall with b_ready low
    b_ready = 1;
    repeat (8) tick();                            // R9: 6, then 5, then 7
    for (int c = 0; c < 6000; c++) begin
      rand_inputs();
      tick();
    end
    drive_aw(0, 0, 0, 0); drive_w(0, 0, 0); b_ready = 1;
    repeat (20) tick();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule